// File: doc/BRIEF.md
# Single-Axis Sub-Pixel Interpolation Filter

This block builds one 8x8 block of predicted 8-bit pixels from a small reference window. It filters along a single axis, horizontal or vertical, at a quarter, half or three-quarter pixel offset. A four-tap kernel is used for every offset. The quarter and three-quarter kernels are asymmetric mirrors of each other. The half-pel kernel is symmetric and has its own bias and shift. Every result is clamped to the pixel range.

The reference window arrives one pixel per handshake beat, in row-major order. For horizontal filtering it is 8 rows of 11 pixels: one column before the block and two after it. For vertical filtering it is 11 rows of 8 pixels: one row above the block and two below it. The configuration inputs are captured on the first accepted beat of the window. In put mode the block then emits 64 pixels on 64 consecutive cycles. In average mode the same input port carries the 64 existing destination pixels, in raster order. Each accepted destination beat yields one averaged output pixel on the next cycle. A one-cycle done pulse marks the 64th output, and the block is then ready for the next window.

Top module: `sp_interp_1d`

## Requirements
- R1: With `cfg_mode` = 1, output = clamp((-4*p[-1] + 53*p[0] + 18*p[1] - 3*p[2] + 32 - r) >>> 6). Here p[-1..2] are the four window pixels that start one position before the output position along the filter axis.
- R2: With `cfg_mode` = 3, output = clamp((-3*p[-1] + 18*p[0] + 53*p[1] - 4*p[2] + 32 - r) >>> 6).
- R3: With `cfg_mode` = 2, output = clamp((-p[-1] + 9*p[0] + 9*p[1] - p[2] + 8 - r) >>> 4).
- R4: Intermediate sums are signed and never wrap. Results below 0 give 0 and results above 255 give 255.
- R5: When `cfg_vert` = 0 (horizontal), r equals `cfg_rnd`. When `cfg_vert` = 1 (vertical), r equals 1 - `cfg_rnd`.
- R6: When `cfg_avg` = 1, each output equals (filtered + dest + 1) >> 1, where dest is the destination pixel accepted on the cycle before the output.
- R7: The window order is fixed. Horizontal windows have 11 columns per row, and output (y,x) uses window pixels (y, x..x+3). Vertical windows have 8 columns per row, and output (y,x) uses window pixels (y..y+3, x). Outputs come out in raster order.
- R8: `in_ready` is high while the window loads. After the window, in put mode `in_ready` is low and outputs appear on consecutive cycles. In average mode `in_ready` stays high, and a cycle without an accepted beat produces no output.
- R9: `out_done` is high together with the 64th `out_valid` of a block and at no other time. The next window may start right after.
- R10: Mode, direction, rounding and average select are sampled on the first window beat. Changes to them later in the block have no effect on its outputs.
- R11: `cfg_mode` = 0 is filtered with the half-pel kernel of R3.
- R12: After reset `out_valid` and `out_done` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat valid (window pixel, or destination pixel in average mode) |
| in_ready | output | 1 | Block accepts the input beat |
| in_pix | input | 8 | Input pixel |
| cfg_mode | input | 2 | Offset: 1 quarter, 2 half, 3 three-quarter, 0 treated as half |
| cfg_vert | input | 1 | 0 horizontal, 1 vertical filtering |
| cfg_rnd | input | 1 | Rounding control bit |
| cfg_avg | input | 1 | 0 put, 1 average with destination |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | 8 | Predicted pixel |
| out_done | output | 1 | Pulse with the last pixel of the block |

## Verification
The bench builds the block with its default parameters: an 8x8 block of 8-bit pixels and an 88-entry window. At that size one full block costs under two hundred cycles, so every combination of the four modes, both directions, both rounding values and both put and average is run against three data patterns. These are a pseudo-random fill, stripes that push the quarter and half kernels past both ends of the pixel range, and a flat white window. Every output pixel is compared with a value computed arithmetically from the window. Input stalls during loading and during averaging, along with configuration inputs changed in the middle of a block, are included in the sweep.

// File: rtl/sp_interp_pkg.sv
// Package: shared types for the single-axis sub-pixel interpolator.
// Assumes nothing beyond IEEE 1800-2017 types.
package sp_interp_pkg;

    // Sub-pixel offset codes (the decoder in sp_tap_kernel depends on them)
    localparam logic [1:0] OFS_HALF_ALIAS = 2'd0;
    localparam logic [1:0] OFS_QUARTER    = 2'd1;
    localparam logic [1:0] OFS_HALF       = 2'd2;
    localparam logic [1:0] OFS_THREEQ     = 2'd3;

    typedef enum logic {
        PH_LOAD = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    typedef struct packed {
        logic [1:0] mode;
        logic       vert;
        logic       rnd;
        logic       avg;
    } blk_cfg_t;

endpackage

// File: rtl/sp_win_buf.sv
// Module: sp_win_buf
// Holds the reference window written one pixel per cycle. It presents four
// taps at base, base+step, base+2*step and base+3*step.
// Assumes the caller keeps every tap address inside DEPTH.
module sp_win_buf #(
    parameter int PIX_W = 8,
    parameter int DEPTH = 88,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [PIX_W-1:0]          wr_data,
    input  logic [AW-1:0]             rd_base,
    input  logic [AW-1:0]             rd_step,
    output logic [3:0][PIX_W-1:0]     taps
);

    logic [PIX_W-1:0] mem [DEPTH];

    // Store one window pixel per accepted beat
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Four read ports spaced by the axis stride
    for (genvar t = 0; t < 4; t++) begin : g_tap
        logic [AW-1:0] addr;
        assign addr    = rd_base + AW'(t) * rd_step;
        assign taps[t] = mem[addr];
    end

endmodule

// File: rtl/sp_tap_kernel.sv
// Module: sp_tap_kernel
// Combinational four-tap filter. It selects the quarter, half or
// three-quarter kernel, adds the offset-specific bias, shifts
// arithmetically, clamps to the pixel range and optionally averages with a
// destination pixel. Assumes taps[0] is the pixel one position before the
// output position along the filter axis.
module sp_tap_kernel #(
    parameter int PIX_W = 8
) (
    input  logic [3:0][PIX_W-1:0] taps,
    input  logic [1:0]            mode,
    input  logic                  rbit,
    input  logic                  avg,
    input  logic [PIX_W-1:0]      dest,
    output logic [PIX_W-1:0]      filt_pix,
    output logic [PIX_W-1:0]      res_pix
);
    import sp_interp_pkg::*;

    localparam int ACC_W = PIX_W + 9;
    localparam logic signed [ACC_W-1:0] K3   = ACC_W'(3);
    localparam logic signed [ACC_W-1:0] K4   = ACC_W'(4);
    localparam logic signed [ACC_W-1:0] K9   = ACC_W'(9);
    localparam logic signed [ACC_W-1:0] K18  = ACC_W'(18);
    localparam logic signed [ACC_W-1:0] K53  = ACC_W'(53);
    localparam logic signed [ACC_W-1:0] B_QT = ACC_W'(32);
    localparam logic signed [ACC_W-1:0] B_HF = ACC_W'(8);
    localparam logic signed [ACC_W-1:0] PMAX = ACC_W'((1 << PIX_W) - 1);

    logic signed [ACC_W-1:0] sa, sb, sc, sd, acc, rext, biased, scaled;
    logic                    long_shift;
    logic [PIX_W:0]          avg_sum;

    // Zero-extend taps into the signed accumulator domain
    always_comb begin
        sa   = signed'({{(ACC_W-PIX_W){1'b0}}, taps[0]});
        sb   = signed'({{(ACC_W-PIX_W){1'b0}}, taps[1]});
        sc   = signed'({{(ACC_W-PIX_W){1'b0}}, taps[2]});
        sd   = signed'({{(ACC_W-PIX_W){1'b0}}, taps[3]});
        rext = signed'({{(ACC_W-1){1'b0}}, rbit});
    end

    // Kernel selection, bias and shift per offset
    always_comb begin
        unique case (mode)
            OFS_QUARTER: begin
                acc        = K53 * sb + K18 * sc - K4 * sa - K3 * sd;
                biased     = acc + B_QT - rext;
                long_shift = 1'b1;
            end
            OFS_THREEQ: begin
                acc        = K18 * sb + K53 * sc - K3 * sa - K4 * sd;
                biased     = acc + B_QT - rext;
                long_shift = 1'b1;
            end
            default: begin
                acc        = K9 * (sb + sc) - sa - sd;
                biased     = acc + B_HF - rext;
                long_shift = 1'b0;
            end
        endcase
        scaled = long_shift ? (biased >>> 6) : (biased >>> 4);
    end

    // Clamp to the pixel range
    always_comb begin
        if (scaled < 0) begin
            filt_pix = '0;
        end else if (scaled > PMAX) begin
            filt_pix = '1;
        end else begin
            filt_pix = scaled[PIX_W-1:0];
        end
    end

    // Optional rounded-up average with the destination pixel
    always_comb begin
        avg_sum = {1'b0, filt_pix} + {1'b0, dest} + {{PIX_W{1'b0}}, 1'b1};
        res_pix = avg ? avg_sum[PIX_W:1] : filt_pix;
    end

endmodule

// File: rtl/sp_seq_ctrl.sv
// Module: sp_seq_ctrl
// Sequencer. It counts window beats into the buffer, captures the
// configuration on the first beat, then walks the output raster and emits
// one pixel per step (every cycle in put mode, every accepted destination
// beat in average mode). Assumes BLK >= 2.
module sp_seq_ctrl #(
    parameter int BLK  = 8,
    parameter int WIN  = BLK * (BLK + 3),
    parameter int AW   = $clog2(WIN),
    parameter int CW   = $clog2(BLK)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  sp_interp_pkg::blk_cfg_t       cfg_in,
    output sp_interp_pkg::blk_cfg_t       cfg_q,
    output logic                          wr_en,
    output logic [AW-1:0]                 wr_addr,
    output logic [AW-1:0]                 rd_base,
    output logic [AW-1:0]                 rd_step,
    output logic                          emit,
    output logic                          emit_last
);
    import sp_interp_pkg::*;

    localparam int SPAN_H = BLK + 3;

    phase_e        ph;
    logic [AW-1:0] wr_idx;
    logic [CW-1:0] row, col;
    logic          accept, load_last, col_end, row_end;

    // Handshake and step decode
    always_comb begin
        in_ready  = (ph == PH_LOAD) || cfg_q.avg;
        accept    = in_valid && in_ready;
        load_last = (ph == PH_LOAD) && accept && (wr_idx == AW'(WIN - 1));
        emit      = (ph == PH_RUN) && (cfg_q.avg ? in_valid : 1'b1);
        col_end   = (col == CW'(BLK - 1));
        row_end   = (row == CW'(BLK - 1));
        emit_last = emit && col_end && row_end;
        wr_en     = (ph == PH_LOAD) && in_valid;
        wr_addr   = wr_idx;
    end

    // Tap base address of the current output along the chosen axis
    always_comb begin
        if (cfg_q.vert) begin
            rd_base = AW'(int'(row) * BLK + int'(col));
            rd_step = AW'(BLK);
        end else begin
            rd_base = AW'(int'(row) * SPAN_H + int'(col));
            rd_step = AW'(1);
        end
    end

    // Phase, beat counter, raster counters and configuration capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph     <= PH_LOAD;
            wr_idx <= '0;
            row    <= '0;
            col    <= '0;
            cfg_q  <= '0;
        end else begin
            unique case (ph)
                PH_LOAD: begin
                    if (accept) begin
                        if (wr_idx == '0) begin
                            cfg_q <= cfg_in;
                        end
                        wr_idx <= load_last ? '0 : wr_idx + 1'b1;
                        if (load_last) begin
                            ph <= PH_RUN;
                        end
                    end
                end
                PH_RUN: begin
                    if (emit) begin
                        col <= col_end ? '0 : col + 1'b1;
                        if (col_end) begin
                            row <= row_end ? '0 : row + 1'b1;
                        end
                        if (emit_last) begin
                            ph <= PH_LOAD;
                        end
                    end
                end
                default: ph <= PH_LOAD;
            endcase
        end
    end

    AST_CFG_HELD_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_RUN) && ($past(ph) == PH_RUN) |-> $stable(cfg_q)); // R10

    AST_WR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < WIN)); // R7

endmodule

// File: rtl/sp_interp_1d.sv
// Module: sp_interp_1d (top)
// Single-axis sub-pixel interpolator for one BLK x BLK block. It loads the
// reference window, filters it along one axis, and emits registered pixels
// in raster order with a done pulse on the last one. Assumes the window is
// streamed row-major with one pixel before and two after the block along
// the filter axis.
module sp_interp_1d #(
    parameter int PIX_W = 8,
    parameter int BLK   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PIX_W-1:0] in_pix,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_vert,
    input  logic             cfg_rnd,
    input  logic             cfg_avg,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix,
    output logic             out_done
);
    import sp_interp_pkg::*;

    localparam int WIN  = BLK * (BLK + 3);
    localparam int AW   = $clog2(WIN);
    localparam int CW   = $clog2(BLK);
    localparam int NPIX = BLK * BLK;
    localparam int NW   = $clog2(NPIX + 1);

    blk_cfg_t             cfg_in, cfg_q;
    logic                 wr_en, emit, emit_last, rbit;
    logic [AW-1:0]        wr_addr, rd_base, rd_step;
    logic [3:0][PIX_W-1:0] taps;
    logic [PIX_W-1:0]     filt_pix, res_pix;

    assign cfg_in = '{mode: cfg_mode, vert: cfg_vert, rnd: cfg_rnd, avg: cfg_avg};
    assign rbit   = cfg_q.vert ? ~cfg_q.rnd : cfg_q.rnd;

    sp_seq_ctrl #(.BLK(BLK), .WIN(WIN), .AW(AW), .CW(CW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .cfg_in    (cfg_in),
        .cfg_q     (cfg_q),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .rd_base   (rd_base),
        .rd_step   (rd_step),
        .emit      (emit),
        .emit_last (emit_last)
    );

    sp_win_buf #(.PIX_W(PIX_W), .DEPTH(WIN), .AW(AW)) u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (in_pix),
        .rd_base (rd_base),
        .rd_step (rd_step),
        .taps    (taps)
    );

    sp_tap_kernel #(.PIX_W(PIX_W)) u_kern (
        .taps     (taps),
        .mode     (cfg_q.mode),
        .rbit     (rbit),
        .avg      (cfg_q.avg),
        .dest     (in_pix),
        .filt_pix (filt_pix),
        .res_pix  (res_pix)
    );

    // Output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_done  <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= emit;
            out_done  <= emit_last;
            if (emit) begin
                out_pix <= res_pix;
            end
        end
    end

    // Independent count of outputs within the current block
    logic [NW-1:0] chk_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_cnt <= '0;
        end else if (out_done) begin
            chk_cnt <= '0;
        end else if (out_valid) begin
            chk_cnt <= chk_cnt + 1'b1;
        end
    end

    AST_DONE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> out_valid); // R9

    AST_DONE_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> (chk_cnt == NW'(NPIX - 1))); // R9

    AST_AVG_NEEDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && cfg_q.avg |-> $past(in_valid)); // R8

    AST_AVG_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && cfg_q.avg |->
            ((out_pix >= $past(filt_pix)) || (out_pix >= $past(in_pix))) &&
            ((out_pix <= $past(filt_pix)) || (out_pix <= $past(in_pix)))); // R6

endmodule

// File: tb/test_sp_interp_1d.sv
module test_sp_interp_1d;

    localparam int BLK  = 8;
    localparam int SPAN = BLK + 3;
    localparam int WIN  = BLK * SPAN;
    localparam int NPIX = BLK * BLK;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_pix = '0;
    logic [1:0] cfg_mode = '0;
    logic       cfg_vert = 1'b0;
    logic       cfg_rnd = 1'b0;
    logic       cfg_avg = 1'b0;
    logic       out_valid;
    logic [7:0] out_pix;
    logic       out_done;

    always #2 clk = ~clk;

    sp_interp_1d i_sp_interp_1d (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_pix(in_pix), .cfg_mode(cfg_mode), .cfg_vert(cfg_vert),
        .cfg_rnd(cfg_rnd), .cfg_avg(cfg_avg), .out_valid(out_valid),
        .out_pix(out_pix), .out_done(out_done)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;
    int    win [WIN];
    int    dst [NPIX];
    int    exp_q [NPIX];
    int    ocnt = 0;
    bit    running = 1'b0;
    bit    blk_done = 1'b0;
    bit    in_run_avg = 1'b0;
    bit    stall_seen = 1'b0;
    string cur_tag = "";
    int unsigned rng = 32'h1234_5678;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int next_rand();
        rng ^= rng << 13;
        rng ^= rng >> 17;
        rng ^= rng << 5;
        return int'(rng & 32'hFF);
    endfunction

    function automatic int tap(input bit vert, input int y, input int x, input int t);
        if (vert) return win[(y + t) * BLK + x];
        return win[y * SPAN + x + t];
    endfunction

    function automatic int expect_pix(input int m, input bit vert, input bit rnd,
                                      input bit avg, input int k);
        int y, x, a, b, c, d, s, bias, sh, r, v;
        y = k / BLK;
        x = k % BLK;
        a = tap(vert, y, x, 0);
        b = tap(vert, y, x, 1);
        c = tap(vert, y, x, 2);
        d = tap(vert, y, x, 3);
        r = vert ? 1 - int'(rnd) : int'(rnd);
        if (m == 1) begin
            s = -4 * a + 53 * b + 18 * c - 3 * d; bias = 32 - r; sh = 6;
        end else if (m == 3) begin
            s = -3 * a + 18 * b + 53 * c - 4 * d; bias = 32 - r; sh = 6;
        end else begin
            s = -a + 9 * b + 9 * c - d; bias = 8 - r; sh = 4;
        end
        v = (s + bias) >>> sh;
        if (v < 0) v = 0;
        if (v > 255) v = 255;
        if (avg) v = (v + dst[k] + 1) >> 1;
        return v;
    endfunction

    // Track cycles in which the average phase saw no destination beat
    always @(posedge clk) stall_seen <= in_run_avg && !in_valid;

    // Output monitor, sampling away from the active edge
    always @(negedge clk) begin
        if (rst_n && running) begin
            if (stall_seen)
                chk(!out_valid, {cur_tag, " R8 stall"}, int'(out_valid), 0);
            if (out_valid) begin
                chk(int'(out_pix) == exp_q[ocnt], cur_tag, int'(out_pix), exp_q[ocnt]);
                chk(out_done == (ocnt == NPIX - 1), "R9 done position",
                    int'(out_done), int'(ocnt == NPIX - 1));
                if (out_done) blk_done = 1'b1;
                ocnt++;
            end else begin
                if (out_done) chk(1'b0, "R9 done without valid", 1, 0);
            end
        end
    end

    task automatic send_beat(input int v, input bit scramble, input bit [4:0] junk);
        forever begin
            @(negedge clk);
            if (scramble) begin
                cfg_mode = junk[1:0];
                cfg_vert = junk[2];
                cfg_rnd  = junk[3];
                cfg_avg  = junk[4];
            end
            in_valid = 1'b1;
            in_pix   = 8'(v);
            if (in_ready) break;
        end
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        in_valid = 1'b0;
        in_pix   = 8'hA5;
    endtask

    task automatic run_block(input int m, input bit vert, input bit rnd,
                             input bit avg, input int pat);
        bit [4:0] junk;
        junk = ~{avg, rnd, vert, 2'(m)};
        // Build window and destination
        for (int i = 0; i < WIN; i++) begin
            int row, col, along;
            row = vert ? i / BLK : i / SPAN;
            col = vert ? i % BLK : i % SPAN;
            along = vert ? row : col;
            if (pat == 0) win[i] = next_rand();
            else if (pat == 1) win[i] = (((along >> 1) & 1) != 0) ? 255 : 0;
            else win[i] = 255;
        end
        for (int k = 0; k < NPIX; k++) dst[k] = (pat == 2) ? 0 : next_rand();
        for (int k = 0; k < NPIX; k++) exp_q[k] = expect_pix(m, vert, rnd, avg, k);
        if (m == 1) cur_tag = "R1 R4 R5 R7 R10";
        else if (m == 3) cur_tag = "R2 R4 R5 R7 R10";
        else if (m == 2) cur_tag = "R3 R4 R5 R7 R10";
        else cur_tag = "R11 R5 R7 R10";
        if (avg) cur_tag = {cur_tag, " R6"};
        ocnt = 0;
        blk_done = 1'b0;
        running = 1'b1;
        cfg_mode = 2'(m);
        cfg_vert = vert;
        cfg_rnd  = rnd;
        cfg_avg  = avg;
        for (int i = 0; i < WIN; i++) begin
            if (pat == 0 && (i % 7) == 3) idle_cycle();
            send_beat(win[i], i > 0, junk);
        end
        idle_cycle();
        chk(in_ready == avg, "R8 ready after load", int'(in_ready), int'(avg));
        if (avg) begin
            in_run_avg = 1'b1;
            for (int k = 0; k < NPIX; k++) begin
                if ((k % 3) == 2) idle_cycle();
                send_beat(dst[k], 1'b1, junk);
            end
            idle_cycle();
        end
        while (!blk_done) @(negedge clk);
        in_run_avg = 1'b0;
        running = 1'b0;
        chk(ocnt == NPIX, "R9 outputs per block", ocnt, NPIX);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid, "R12 out_valid after reset", int'(out_valid), 0);
        chk(!out_done, "R12 out_done after reset", int'(out_done), 0);
        chk(in_ready, "R12 in_ready after reset", int'(in_ready), 1);
        for (int m = 0; m < 4; m++)
            for (int dv = 0; dv < 2; dv++)
                for (int rb = 0; rb < 2; rb++)
                    for (int av = 0; av < 2; av++)
                        for (int p = 0; p < 3; p++)
                            run_block(m, dv[0], rb[0], av[0], p);
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R9 watchdog: actual no completion expected completion");
            summary();
            $finish;
        end
    end

endmodule